// File: doc/BRIEF.md
# Receive Destination Address Screen

This block sits on the byte stream of an Ethernet receive path and decides, frame by frame, whether the frame is meant for this station. It collects the first six bytes of each frame, which form the destination address, and compares them against a programmed station address, the all-ones broadcast address and a 64-bit multicast hash table. Promiscuous mode accepts everything. When receive is disabled at the start of a frame, that frame never leaves the block.

The same stream is passed through to the output one cycle later. Frames shorter than the minimum length are extended with zero bytes. Padding takes priority over new input, and the block lowers `in_ready` while it pads. One verdict pulse per admitted frame carries the accept flag and a two-bit reason. Software loads the station address, the hash table and the control bits through a 16-bit write port.

Top module: `rx_dest_screen`

## Requirements
- R1: Control register at write address 7 holds bit 0 receive-on, bit 1 promiscuous and bit 2 hash-on. All configuration is zero after reset. A frame whose first byte (`in_sof`) arrives while receive-on is 0 produces no output bytes and no verdict.
- R2: While promiscuous is 1, every verdict is accept with reason 3, whatever the address and even if it would also match another rule.
- R3: Station words sit at write addresses 0, 1 and 2. Word n holds destination byte 2n in bits [15:8] and byte 2n+1 in bits [7:0]. An exact six-byte match gives accept with reason 0.
- R4: A destination of FF:FF:FF:FF:FF:FF that does not match the station address gives accept with reason 1.
- R5: The hash index is bits [31:26] of a CRC-32 over the six destination bytes. The CRC starts at all ones, uses the reflected polynomial EDB88320h, takes each byte least significant bit first, and is not inverted at the end.
- R6: Hash word k (k = 0..3) is written at address 6-k and holds indices 16k..16k+15, with the bit chosen by index bits [3:0]. When no earlier rule matches, a frame is accepted with reason 2 only if hash-on is 1 and that bit is 1.
- R7: A frame that matches no rule gets a reject verdict (accept 0) with reason field 0.
- R8: A frame of fewer than 60 bytes is output with zero bytes appended up to 60 bytes, and `out_eof` marks the 60th byte. `in_ready` is low while padding. A frame of 60 bytes or more is output unchanged, with `out_eof` on its own last byte.
- R9: Each admitted input byte appears on the output exactly one cycle after it is taken, with `out_sof` on the first byte.
- R10: The verdict is valid for exactly one cycle, one cycle after the sixth output byte of the frame. For frames shorter than six bytes, the address bytes that are missing are taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Low while pad bytes are being inserted |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |
| out_data | output | 8 | Output byte |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_why | output | 2 | Reason: 0 station, 1 broadcast, 2 hash, 3 promiscuous |

## Verification
The bench sweeps 64 multicast addresses. For each one it writes a table with only the predicted hash bit set, then a table with only that bit clear. A wrong CRC seed, bit order or final inversion, or a word numbering that does not count down, turns one of each pair into a wrong verdict. Station addresses with a single flipped bit in each byte position catch a byte-order swap in the station registers. Frames of 1, 3, 20, 59, 60 and 61 bytes catch an off-by-one in the pad length, a pad byte that is not zero, and a missing verdict when the address itself is padded. Promiscuous frames that also match the station address show whether the rule priority is inverted.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int OCTET_W    = 8;
    localparam int DST_OCTETS = 6;
    localparam int WORD_W     = 16;
    localparam int STA_WORDS  = 3;
    localparam int HASH_WORDS = 4;
    localparam int HASH_IDX_W = 6;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        WHY_STATION = 2'd0,
        WHY_BCAST   = 2'd1,
        WHY_HASH    = 2'd2,
        WHY_PROMISC = 2'd3
    } why_e;

    typedef struct packed {
        logic rx_on;
        logic promisc;
        logic hash_on;
    } ctl_t;

    typedef struct packed {
        logic accept;
        why_e why;
    } verdict_t;

    // One byte of a reflected CRC, least significant bit first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                   input logic [OCTET_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-OCTET_W){1'b0}}, b};
        for (int i = 0; i < OCTET_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rxs_cfg.sv
module rxs_cfg
    import rxs_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [AW-1:0]                    addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [DST_OCTETS*OCTET_W-1:0]    station,
    output logic [HASH_WORDS*WORD_W-1:0]     hash_tbl,
    output ctl_t                             ctl
);
    localparam int HASH_TOP = STA_WORDS + HASH_WORDS - 1;
    localparam int CTL_ADDR = HASH_TOP + 1;

    // Station word 0 lands in the top bits: it carries the first bytes on the wire
    for (genvar i = 0; i < STA_WORDS; i++) begin : g_sta
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                             q <= '0;
            else if (we && addr == AW'(i))       q <= wdata;
        end
        assign station[(STA_WORDS-1-i)*WORD_W +: WORD_W] = q;
    end

    // Hash words are numbered downward from the highest address
    for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                 q <= '0;
            else if (we && addr == AW'(HASH_TOP-k))  q <= wdata;
        end
        assign hash_tbl[k*WORD_W +: WORD_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (we && addr == AW'(CTL_ADDR)) begin
            ctl.rx_on   <= wdata[0];
            ctl.promisc <= wdata[1];
            ctl.hash_on <= wdata[2];
        end
    end
endmodule

// File: rtl/rxs_pad.sv
module rxs_pad
    import rxs_pkg::*;
#(
    parameter int MIN_LEN = 60,
    localparam int IDX_W  = $clog2(MIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_on,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [OCTET_W-1:0] in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_eof,
    output logic [OCTET_W-1:0] out_data,
    output logic [IDX_W-1:0]   out_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MIN_LEN - 1);
    localparam logic [IDX_W-1:0] FULL = IDX_W'(MIN_LEN);

    logic             in_frame_q, pad_q, take;
    logic [IDX_W-1:0] cnt_q, idx_n, cnt_n;

    assign in_ready = !pad_q;
    assign take     = in_valid && in_ready && (in_sof ? rx_on : in_frame_q);
    assign idx_n    = in_sof ? '0 : cnt_q;
    assign cnt_n    = (idx_n == FULL) ? FULL : idx_n + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            pad_q      <= 1'b0;
            cnt_q      <= '0;
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_data   <= '0;
            out_idx    <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            if (pad_q) begin
                out_valid <= 1'b1;
                out_data  <= '0;
                out_idx   <= cnt_q;
                cnt_q     <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    out_eof <= 1'b1;
                    pad_q   <= 1'b0;
                end
            end else if (take) begin
                out_valid <= 1'b1;
                out_data  <= in_data;
                out_sof   <= in_sof;
                out_idx   <= idx_n;
                cnt_q     <= cnt_n;
                if (in_eof) begin
                    in_frame_q <= 1'b0;
                    if (idx_n >= LAST) out_eof <= 1'b1;
                    else               pad_q   <= 1'b1;
                end else begin
                    in_frame_q <= 1'b1;
                end
            end else if (in_valid && in_ready && in_sof) begin
                in_frame_q <= 1'b0;
            end
        end
    end

    AST_SOF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof |-> $past(rx_on)); // R1
    AST_EOF_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eof |-> out_idx >= LAST); // R8
    AST_ONE_CYCLE_THROUGH: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof |-> $past(in_valid && in_sof)); // R9
endmodule

// File: rtl/rxs_match.sv
module rxs_match
    import rxs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          byte_valid,
    input  logic [IDX_W-1:0]              byte_idx,
    input  logic [OCTET_W-1:0]            byte_data,
    input  logic [DST_OCTETS*OCTET_W-1:0] station,
    input  logic [HASH_WORDS*WORD_W-1:0]  hash_tbl,
    input  logic                          promisc,
    input  logic                          hash_on,
    output logic                          dec_valid,
    output logic                          dec_accept,
    output logic [1:0]                    dec_why
);
    localparam int HEAD_W = (DST_OCTETS - 1) * OCTET_W;
    localparam logic [IDX_W-1:0] DST_LAST = IDX_W'(DST_OCTETS - 1);

    logic [HEAD_W-1:0]              head_q;
    logic [CRC_W-1:0]               crc_q, crc_in, crc_n;
    logic [DST_OCTETS*OCTET_W-1:0]  dst;
    logic [HASH_IDX_W-1:0]          hidx;
    logic                           hash_hit, dv_q;
    verdict_t                       v_n, v_q;

    assign crc_in   = (byte_idx == '0) ? CRC_SEED : crc_q;
    assign crc_n    = crc_step(crc_in, byte_data);
    assign dst      = {head_q, byte_data};
    assign hidx     = crc_n[CRC_W-1 -: HASH_IDX_W];
    assign hash_hit = hash_tbl[hidx];

    // Rule priority: promiscuous, station, broadcast, hash
    always_comb begin
        v_n = '{accept: 1'b0, why: WHY_STATION};
        if (promisc)                 v_n = '{accept: 1'b1, why: WHY_PROMISC};
        else if (dst == station)     v_n = '{accept: 1'b1, why: WHY_STATION};
        else if (&dst)               v_n = '{accept: 1'b1, why: WHY_BCAST};
        else if (hash_on && hash_hit) v_n = '{accept: 1'b1, why: WHY_HASH};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            crc_q  <= CRC_SEED;
            dv_q   <= 1'b0;
            v_q    <= '0;
        end else begin
            dv_q <= 1'b0;
            if (byte_valid && byte_idx < DST_LAST) begin
                head_q <= {head_q[HEAD_W-OCTET_W-1:0], byte_data};
                crc_q  <= crc_n;
            end
            if (byte_valid && byte_idx == DST_LAST) begin
                dv_q <= 1'b1;
                v_q  <= v_n;
            end
        end
    end

    assign dec_valid  = dv_q;
    assign dec_accept = v_q.accept;
    assign dec_why    = v_q.why;

    AST_DEC_SLOT: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(byte_valid && byte_idx == DST_LAST)); // R10
    AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid); // R10
    AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (rst)
        dec_valid && $past(promisc) |-> dec_accept && dec_why == WHY_PROMISC); // R2
    AST_REJECT_CODE: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_accept |-> dec_why == WHY_STATION); // R7
    AST_HASH_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_accept && dec_why == WHY_HASH |-> $past(hash_on)); // R6
endmodule

// File: rtl/rx_dest_screen.sv
module rx_dest_screen
    import rxs_pkg::*;
#(
    parameter int MIN_LEN = 60,
    parameter int CFG_AW  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [15:0]        cfg_wdata,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_eof,
    output logic [7:0]         out_data,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic [1:0]         dec_why
);
    localparam int IDX_W = $clog2(MIN_LEN + 1);

    logic [DST_OCTETS*OCTET_W-1:0] station;
    logic [HASH_WORDS*WORD_W-1:0]  hash_tbl;
    ctl_t                          ctl;
    logic [IDX_W-1:0]              out_idx;

    rxs_cfg #(.AW(CFG_AW)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .station(station), .hash_tbl(hash_tbl), .ctl(ctl)
    );

    rxs_pad #(.MIN_LEN(MIN_LEN)) pad_i (
        .clk(clk), .rst(rst), .rx_on(ctl.rx_on),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_data(out_data), .out_idx(out_idx)
    );

    rxs_match #(.IDX_W(IDX_W)) match_i (
        .clk(clk), .rst(rst),
        .byte_valid(out_valid), .byte_idx(out_idx), .byte_data(out_data),
        .station(station), .hash_tbl(hash_tbl),
        .promisc(ctl.promisc), .hash_on(ctl.hash_on),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_why(dec_why)
    );
endmodule

// File: tb/rx_dest_screen_tb_top.sv
module rx_dest_screen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [15:0] cfg_wdata = 0;
    logic        in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, out_valid, out_sof, out_eof, dec_valid, dec_accept;
    logic [7:0]  out_data;
    logic [1:0]  dec_why;

    rx_dest_screen dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_data(out_data), .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_why(dec_why)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled on the falling edge
    logic [7:0] m_byte [128];
    logic       m_sof  [128];
    logic       m_eof  [128];
    int         m_cyc  [128];
    int         m_tot = 0, d_tot = 0, d_cyc = 0;
    logic       d_acc = 0;
    logic [1:0] d_why = 0;
    always @(negedge clk) begin
        if (out_valid) begin
            m_byte[m_tot % 128] = out_data;
            m_sof[m_tot % 128]  = out_sof;
            m_eof[m_tot % 128]  = out_eof;
            m_cyc[m_tot % 128]  = cyc;
            m_tot++;
        end
        if (dec_valid) begin
            d_tot++;
            d_cyc = cyc;
            d_acc = dec_accept;
            d_why = dec_why;
        end
    end

    // Bench copy of the configuration
    logic [7:0]  sta [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    logic [15:0] hw  [4] = '{16'h0, 16'h0, 16'h0, 16'h0};
    bit en = 0, prom = 0, hen = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] v);
        cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_ctl(input bit e, input bit p, input bit h);
        en = e; prom = p; hen = h;
        wr(7, {13'b0, h, p, e});
    endtask

    task automatic load_station();
        for (int n = 0; n < 3; n++) wr(n, {sta[2*n], sta[2*n+1]});
    endtask

    task automatic load_hash();
        for (int k = 0; k < 4; k++) wr(6 - k, hw[k]);
    endtask

    function automatic int hidx_of(input logic [7:0] d [6]);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            c = c ^ {24'h0, d[b]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return int'(c[31:26]);
    endfunction

    function automatic logic [7:0] pay(input int i, input logic [7:0] d [6]);
        if (i < 6) return d[i];
        return 8'(i * 3) | 8'h01;
    endfunction

    task automatic exp_dec(input logic [7:0] d [6], output bit acc, output logic [1:0] why);
        bit same, ones;
        int ix;
        same = 1; ones = 1;
        for (int b = 0; b < 6; b++) begin
            if (d[b] != sta[b]) same = 0;
            if (d[b] != 8'hFF) ones = 0;
        end
        ix = hidx_of(d);
        acc = 0; why = 2'd0;
        if (prom)                              begin acc = 1; why = 2'd3; end
        else if (same)                         begin acc = 1; why = 2'd0; end
        else if (ones)                         begin acc = 1; why = 2'd1; end
        else if (hen && hw[ix / 16][ix % 16])  begin acc = 1; why = 2'd2; end
    endtask

    task automatic run_frame(input int len, input logic [7:0] d [6], input string tag);
        int s0, dd0, drive_c, exp_len, bad;
        logic [7:0] full [6];
        bit acc;
        logic [1:0] why;
        s0 = m_tot; dd0 = d_tot; drive_c = 0;
        for (int i = 0; i < len; i++) begin
            while (!in_ready) begin
                in_valid = 0;
                @(negedge clk);
            end
            if (i == 0) drive_c = cyc;
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = pay(i, d);
            @(negedge clk);
        end
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
        repeat (80) @(negedge clk);
        for (int b = 0; b < 6; b++) full[b] = (b < len) ? d[b] : 8'h00;
        if (!en) begin
            chk(m_tot == s0, {tag, " R1 bytes out while disabled"}, m_tot - s0, 0);
            chk(d_tot == dd0, {tag, " R1 verdicts while disabled"}, d_tot - dd0, 0);
            return;
        end
        exp_len = (len < 60) ? 60 : len;
        chk(m_tot - s0 == exp_len, {tag, " R8 output length"}, m_tot - s0, exp_len);
        if (m_tot - s0 == exp_len) begin
            bad = 0;
            for (int i = 0; i < exp_len; i++) begin
                if (m_byte[(s0+i)%128] != ((i < len) ? pay(i, d) : 8'h00)) bad++;
                if (m_eof[(s0+i)%128] != (i == exp_len - 1)) bad++;
                if (m_sof[(s0+i)%128] != (i == 0)) bad++;
            end
            chk(bad == 0, {tag, " R8 bytes and markers"}, bad, 0);
            chk(m_cyc[s0%128] == drive_c + 1, {tag, " R9 first byte cycle"},
                m_cyc[s0%128], drive_c + 1);
            chk(d_cyc == m_cyc[(s0+5)%128] + 1, {tag, " R10 verdict cycle"},
                d_cyc, m_cyc[(s0+5)%128] + 1);
        end
        chk(d_tot - dd0 == 1, {tag, " R10 verdict count"}, d_tot - dd0, 1);
        exp_dec(full, acc, why);
        chk(d_acc == acc, {tag, " accept"}, int'(d_acc), int'(acc));
        chk(d_why == why, {tag, " reason"}, int'(d_why), int'(why));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] bc [6]  = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        logic [7:0] oth [6] = '{8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F};
        logic [7:0] tmp [6];
        int ix;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
        chk(dec_valid == 0, "R1 reset dec_valid", int'(dec_valid), 0);
        chk(in_ready == 1, "R8 reset in_ready", int'(in_ready), 1);

        run_frame(64, sta, "R1 after reset");

        load_station();
        set_ctl(1, 0, 0);
        run_frame(64, sta, "R3 station");
        run_frame(60, bc, "R4 broadcast");
        run_frame(61, oth, "R7 no match");
        run_frame(20, sta, "R8 short station");
        run_frame(59, oth, "R8 len 59");
        run_frame(3, sta, "R8 R10 three bytes");
        run_frame(1, bc, "R8 R10 one byte");
        for (int b = 0; b < 6; b++) begin
            tmp = sta;
            tmp[b] = tmp[b] ^ 8'h10;
            run_frame(62, tmp, "R3 near miss");
        end

        set_ctl(1, 1, 0);
        run_frame(64, oth, "R2 promiscuous other");
        run_frame(64, sta, "R2 promiscuous station");
        run_frame(10, bc, "R2 promiscuous short");

        set_ctl(1, 0, 1);
        for (int k = 0; k < 64; k++) begin
            tmp = '{8'h01, 8'h00, 8'h5E, 8'(k * 5), 8'h20, 8'(k)};
            ix = hidx_of(tmp);
            for (int w = 0; w < 4; w++) hw[w] = (w == ix / 16) ? (16'h1 << (ix % 16)) : 16'h0;
            load_hash();
            run_frame(60, tmp, "R5 R6 hash bit set");
            for (int w = 0; w < 4; w++) hw[w] = ~((w == ix / 16) ? (16'h1 << (ix % 16)) : 16'h0);
            load_hash();
            run_frame(60, tmp, "R5 R6 hash bit clear");
        end
        run_frame(60, sta, "R3 station with hash on");

        tmp = '{8'h01, 8'h00, 8'h5E, 8'h11, 8'h22, 8'h33};
        ix = hidx_of(tmp);
        for (int w = 0; w < 4; w++) hw[w] = (w == ix / 16) ? (16'h1 << (ix % 16)) : 16'h0;
        load_hash();
        set_ctl(1, 0, 0);
        run_frame(60, tmp, "R6 hash off");

        set_ctl(0, 0, 0);
        run_frame(64, bc, "R1 disabled again");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule